// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the message-signalled-interrupt capability structure of one PCI function. A configuration-space slave port presents dword-addressed reads and writes with byte enables. The block decides which bytes fall inside the capability, applies a write mask to each field, and publishes the programmed state to a separate message generator. That state is the enable bit, the enabled vector count, the 64-bit message address, the 16-bit message data, and the per-vector mask and pending words. The generator reports vectors it could not send because they were masked through a pending-set input. It clears them through a pending-clear input once they have been delivered.

Elaboration parameters pick one of four layouts. They are 32-bit or 64-bit addressing, each with or without per-vector masking. The capability length is 10, 14, 20 or 24 bytes. The data field sits behind the address words, and the mask and pending words follow the data. While MSI is enabled the function's legacy INTx request is held off. Every write that overlaps the capability raises a one-cycle update strobe so the generator can rescan its pending vectors.

Top module: `msi_cap_regs`

## Requirements
- R1: The dword at the capability pointer reads back the structure's first bytes: byte 0 is capability ID 0x05 and byte 1 is the next pointer. Bytes 2 and 3 are the control word, with bit 0 enable, bits [3:1] the capable vector count as log2, bits [6:4] the enabled vector count as log2, bit 7 the 64-bit flag and bit 8 the per-vector-mask flag.
- R2: In the control word only the enable bit and the enabled-count field accept writes. The ID, the next pointer, the capable count and both flags keep their values under any write.
- R3: Message address bits [1:0] always read zero. The high address word sits at capability offset 0x8 and is writable only in the 64-bit layout. In the 32-bit layout the address upper half is zero.
- R4: The message data is 16 writable bits at offset 0x8 (32-bit) or 0xC (64-bit). The upper half of that dword reads zero.
- R5: With masking, the mask word sits 4 bytes after the data dword. Only mask bits 0 to 2^capable−1 can be set.
- R6: Reset clears enable, the enabled count, both address words, the data, the mask and the pending word. The read-only header fields are unchanged by reset.
- R7: When a capability write leaves MSI enabled and the enabled count is above the capable count, the count is replaced by the capable count. A value written while disabled is stored unchanged.
- R8: The INTx output equals the INTx request while MSI is disabled and is 0 while it is enabled.
- R9: A write whose enabled bytes all lie outside the capability's byte range changes no register and raises no update strobe. Such bytes read as zero.
- R10: The pending word sits 4 bytes after the mask. After a capability write that leaves MSI enabled, pending bits at or above 2^enabled-count are cleared. Without enable, the pending word is kept.
- R11: A pending-set pulse sets pending bits below 2^capable only, and a pending-clear pulse clears the bits it names. Without masking the pending word stays zero.
- R12: The update strobe is high for exactly the cycle after each clock edge that takes a write overlapping the capability.
- R13: Read data appears one cycle after a read request, flagged by a read-valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write request |
| cfg_rd | input | 1 | Configuration read request |
| cfg_addr | input | ADDR_W | Dword address in configuration space |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| pend_set | input | 32 | Vectors to mark pending |
| pend_clr | input | 32 | Vectors to clear from pending |
| intx_in | input | 1 | Legacy interrupt request of the function |
| intx_out | output | 1 | Legacy interrupt request after MSI gating |
| msi_enable | output | 1 | MSI enable bit |
| msi_mme | output | 3 | Enabled vector count, log2 |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | 32 | Per-vector mask word |
| msi_pending | output | 32 | Per-vector pending word |
| cfg_updated | output | 1 | One-cycle strobe after a capability write |

## Verification
The hardest state to reach from the ports is a pending word that holds vectors above the newly enabled count at the moment an enabling write lands. The bench first fills the pending word through the pending-set port while MSI is off. It then writes a count larger than the capable one with enable still clear, to show the raw value is kept and nothing is trimmed. Finally it enables with a small count, so that the trim and the clamp are both seen. A second instance built in the 32-bit layout without masking checks the byte-range edges: the unused half of the data dword and the dword past the end.

// File: rtl/msi_cap_pkg.sv
// Package: constants, layout slots and helper functions shared by the
// MSI capability block. Assumes dword-aligned capability placement.
package msi_cap_pkg;

    localparam logic [7:0] MSI_CAP_ID = 8'h05;
    localparam int         VEC_MAX    = 32;

    // Control word bit positions within the header dword
    localparam int CTL_EN  = 16;
    localparam int CTL_MME = 20;

    // Which register a capability-relative dword selects
    typedef enum logic [2:0] {
        SLOT_HDR,
        SLOT_ALO,
        SLOT_AHI,
        SLOT_DATA,
        SLOT_MASK,
        SLOT_PEND,
        SLOT_NONE
    } slot_e;

    // Capability length in bytes for each layout variant
    function automatic logic [7:0] cap_len(input logic is64, input logic pvm);
        case ({pvm, is64})
            2'b00:   return 8'h0A;
            2'b01:   return 8'h0E;
            2'b10:   return 8'h14;
            default: return 8'h18;
        endcase
    endfunction

    // Map a capability-relative dword index to its register
    function automatic slot_e slot_for(input logic [2:0] dw, input logic is64,
                                       input logic pvm);
        case (dw)
            3'd0:    return SLOT_HDR;
            3'd1:    return SLOT_ALO;
            3'd2:    return is64 ? SLOT_AHI : SLOT_DATA;
            3'd3:    return is64 ? SLOT_DATA : (pvm ? SLOT_MASK : SLOT_NONE);
            3'd4:    return pvm ? (is64 ? SLOT_MASK : SLOT_PEND) : SLOT_NONE;
            3'd5:    return (pvm && is64) ? SLOT_PEND : SLOT_NONE;
            default: return SLOT_NONE;
        endcase
    endfunction

    // Bit vector with the low 2^lg bits set (lg saturates at 5)
    function automatic logic [31:0] vec_bits(input logic [2:0] lg);
        logic [2:0] l;
        logic [5:0] n;
        l = (lg > 3'd5) ? 3'd5 : lg;
        n = 6'd1 << l;
        return 32'hFFFF_FFFF >> (6'd32 - n);
    endfunction

endpackage

// File: rtl/msi_cap_decode.sv
// Address decode: finds which capability register a dword address hits and
// which byte lanes fall inside the capability's byte range.
// Assumes CAP_PTR is dword aligned and the structure fits the address space.
module msi_cap_decode
    import msi_cap_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter logic [7:0] CAP_PTR  = 8'h50,
    parameter bit         IS_64    = 1'b1,
    parameter bit         HAS_MASK = 1'b1
) (
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    output slot_e             slot,
    output logic [3:0]        lane_in,
    output logic [3:0]        lane_hit
);

    localparam int BASE    = int'(CAP_PTR);
    localparam int LEN     = int'(cap_len(IS_64, HAS_MASK));
    localparam int BASE_DW = BASE / 4;

    int rel_dw;

    // Select the register addressed by the capability-relative dword
    always_comb begin
        rel_dw = int'(cfg_addr) - BASE_DW;
        if (rel_dw >= 0 && rel_dw < 8)
            slot = slot_for(3'(rel_dw), IS_64, HAS_MASK);
        else
            slot = SLOT_NONE;
    end

    // Per-lane range test against the capability's byte span
    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [ADDR_W+1:0] byte_addr;
        assign byte_addr  = {cfg_addr, 2'(l)};
        assign lane_in[l] = (int'(byte_addr) >= BASE) && (int'(byte_addr) < BASE + LEN);
    end

    assign lane_hit = lane_in & cfg_be;

endmodule

// File: rtl/msi_cap_ctrl.sv
// Control state: enable bit and enabled vector count, with the clamp of an
// over-large count applied on any capability write that leaves MSI enabled.
// Assumes ctl_byte is byte 2 of the header dword (bits 23:16).
module msi_cap_ctrl #(
    parameter int MMC_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctl,
    input  logic [7:0] ctl_byte,
    input  logic       cap_wr,
    output logic       en_q,
    output logic [2:0] mme_q,
    output logic       en_d,
    output logic [2:0] mme_d
);

    localparam logic [2:0] MMC = 3'(MMC_LOG2);

    // Next-state of enable and count, including the clamp
    always_comb begin
        en_d  = en_q;
        mme_d = mme_q;
        if (wr_ctl) begin
            en_d  = ctl_byte[0];
            mme_d = ctl_byte[6:4];
        end
        if (cap_wr && en_d && (mme_d > MMC))
            mme_d = MMC;
    end

    // Control register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            mme_q <= 3'd0;
        end else begin
            en_q  <= en_d;
            mme_q <= mme_d;
        end
    end

endmodule

// File: rtl/msi_cap_addr.sv
// Message address and data registers with byte-lane writes. Address bits
// [1:0] are forced to zero; the high word exists only in the 64-bit layout.
module msi_cap_addr #(
    parameter bit IS_64 = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic        wr_data,
    input  logic [3:0]  lanes,
    input  logic [31:0] wdata,
    output logic [31:0] addr_lo,
    output logic [31:0] addr_hi,
    output logic [15:0] data
);

    // Low address word, byte writable, bits [1:0] held at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo <= '0;
        end else if (wr_lo) begin
            for (int b = 0; b < 4; b++)
                if (lanes[b]) addr_lo[8*b +: 8] <= wdata[8*b +: 8];
            addr_lo[1:0] <= 2'b00;
        end
    end

    // Message data, lanes 0 and 1 only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (wr_data) begin
            for (int b = 0; b < 2; b++)
                if (lanes[b]) data[8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    if (IS_64) begin : g_hi
        // High address word, fully writable
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_hi <= '0;
            end else if (wr_hi) begin
                for (int b = 0; b < 4; b++)
                    if (lanes[b]) addr_hi[8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end else begin : g_no_hi
        assign addr_hi = '0;
    end

endmodule

// File: rtl/msi_cap_vec.sv
// Per-vector mask and pending words. Only vectors below the capable count
// are stored. Pending is set/cleared by the message generator and trimmed
// to the enabled count when an enabling capability write lands.
module msi_cap_vec
    import msi_cap_pkg::*;
#(
    parameter bit HAS_MASK = 1'b1,
    parameter int MMC_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_mask,
    input  logic [3:0]  lanes,
    input  logic [31:0] wdata,
    input  logic [31:0] pend_set,
    input  logic [31:0] pend_clr,
    input  logic        trim,
    input  logic [2:0]  mme_d,
    output logic [31:0] mask_q,
    output logic [31:0] pend_q
);

    if (HAS_MASK) begin : g_mask
        localparam logic [31:0] CAP_BITS = vec_bits(3'(MMC_LOG2));

        logic [31:0] mask_d;
        logic [31:0] pend_d;

        // Mask next-state: byte-lane write limited to capable vectors
        always_comb begin
            mask_d = mask_q;
            if (wr_mask)
                for (int b = 0; b < 4; b++)
                    if (lanes[b]) mask_d[8*b +: 8] = wdata[8*b +: 8] & CAP_BITS[8*b +: 8];
        end

        // Pending next-state: set, then clear, then trim on enabling write
        always_comb begin
            pend_d = (pend_q | (pend_set & CAP_BITS)) & ~pend_clr;
            if (trim)
                pend_d = pend_d & vec_bits(mme_d);
        end

        // Mask and pending registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
                pend_q <= '0;
            end else begin
                mask_q <= mask_d;
                pend_q <= pend_d;
            end
        end
    end else begin : g_no_mask
        assign mask_q = '0;
        assign pend_q = '0;
    end

endmodule

// File: rtl/msi_cap_regs.sv
// MSI capability register block top: decodes config accesses, owns the
// read mux, gates INTx while MSI is on and emits the update strobe.
// Assumes CAP_PTR is dword aligned and MMC_LOG2 is 0..5.
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter logic [7:0] CAP_PTR  = 8'h50,
    parameter logic [7:0] NEXT_PTR = 8'h60,
    parameter bit         IS_64    = 1'b1,
    parameter bit         HAS_MASK = 1'b1,
    parameter int         MMC_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_rvalid,
    input  logic [31:0]       pend_set,
    input  logic [31:0]       pend_clr,
    input  logic              intx_in,
    output logic              intx_out,
    output logic              msi_enable,
    output logic [2:0]        msi_mme,
    output logic [63:0]       msi_addr,
    output logic [15:0]       msi_data,
    output logic [31:0]       msi_mask,
    output logic [31:0]       msi_pending,
    output logic              cfg_updated
);

    slot_e       slot;
    logic [3:0]  lane_in;
    logic [3:0]  lane_hit;
    logic [3:0]  wr_lanes;
    logic        cap_wr;
    logic        en_q, en_d;
    logic [2:0]  mme_q, mme_d;
    logic [31:0] addr_lo, addr_hi;
    logic [15:0] data_q;
    logic [31:0] mask_q, pend_q;
    logic [15:0] ctl_word;
    logic [31:0] rd_word;
    logic [31:0] rd_masked;
    logic [31:0] rdata_q;
    logic        rvalid_q;
    logic        upd_q;

    msi_cap_decode #(
        .ADDR_W(ADDR_W), .CAP_PTR(CAP_PTR), .IS_64(IS_64), .HAS_MASK(HAS_MASK)
    ) u_dec (
        .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .slot(slot), .lane_in(lane_in), .lane_hit(lane_hit)
    );

    assign wr_lanes = cfg_wr ? lane_hit : 4'b0000;
    assign cap_wr   = |wr_lanes;

    msi_cap_ctrl #(.MMC_LOG2(MMC_LOG2)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctl(wr_lanes[2] && slot == SLOT_HDR),
        .ctl_byte(cfg_wdata[CTL_EN +: 8]),
        .cap_wr(cap_wr),
        .en_q(en_q), .mme_q(mme_q), .en_d(en_d), .mme_d(mme_d)
    );

    msi_cap_addr #(.IS_64(IS_64)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(cap_wr && slot == SLOT_ALO),
        .wr_hi(cap_wr && slot == SLOT_AHI),
        .wr_data(cap_wr && slot == SLOT_DATA),
        .lanes(wr_lanes), .wdata(cfg_wdata),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .data(data_q)
    );

    msi_cap_vec #(.HAS_MASK(HAS_MASK), .MMC_LOG2(MMC_LOG2)) u_vec (
        .clk(clk), .rst_n(rst_n),
        .wr_mask(cap_wr && slot == SLOT_MASK),
        .lanes(wr_lanes), .wdata(cfg_wdata),
        .pend_set(pend_set), .pend_clr(pend_clr),
        .trim(cap_wr && en_d), .mme_d(mme_d),
        .mask_q(mask_q), .pend_q(pend_q)
    );

    assign ctl_word = {7'b0, HAS_MASK, IS_64, mme_q, 3'(MMC_LOG2), en_q};

    // Read mux by register slot, bytes outside the capability forced to zero
    always_comb begin
        case (slot)
            SLOT_HDR:  rd_word = {ctl_word, NEXT_PTR, MSI_CAP_ID};
            SLOT_ALO:  rd_word = addr_lo;
            SLOT_AHI:  rd_word = addr_hi;
            SLOT_DATA: rd_word = {16'h0000, data_q};
            SLOT_MASK: rd_word = mask_q;
            SLOT_PEND: rd_word = pend_q;
            default:   rd_word = '0;
        endcase
        for (int b = 0; b < 4; b++)
            rd_masked[8*b +: 8] = lane_in[b] ? rd_word[8*b +: 8] : 8'h00;
    end

    // Registered read return and update strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            upd_q    <= 1'b0;
        end else begin
            rvalid_q <= cfg_rd;
            upd_q    <= cap_wr;
            if (cfg_rd) rdata_q <= rd_masked;
        end
    end

    assign cfg_rdata   = rdata_q;
    assign cfg_rvalid  = rvalid_q;
    assign cfg_updated = upd_q;
    assign intx_out    = intx_in & ~en_q;
    assign msi_enable  = en_q;
    assign msi_mme     = mme_q;
    assign msi_addr    = {addr_hi, addr_lo};
    assign msi_data    = data_q;
    assign msi_mask    = mask_q;
    assign msi_pending = pend_q;

endmodule

// File: rtl/msi_cap_regs_chk.sv
// Checker for msi_cap_regs: temporal properties over the top's ports.
// Attached to every instance of the top by the bind at the end of the file.
module msi_cap_regs_chk
    import msi_cap_pkg::*;
#(
    parameter int MMC_LOG2 = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic        intx_in,
    input logic        intx_out,
    input logic        msi_enable,
    input logic [2:0]  msi_mme,
    input logic [63:0] msi_addr,
    input logic [31:0] msi_mask,
    input logic [31:0] msi_pending,
    input logic        cfg_updated
);

    localparam logic [31:0] CAP_BITS = vec_bits(3'(MMC_LOG2));

    assert_intx_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_enable |-> !intx_out);

    assert_intx_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!msi_enable && intx_in) |-> intx_out);

    assert_mme_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_updated && msi_enable) |-> (msi_mme <= 3'(MMC_LOG2)));

    assert_pend_trim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_updated && msi_enable) |-> ((msi_pending & ~vec_bits(msi_mme)) == 32'h0));

    assert_mask_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_mask & ~CAP_BITS) == 32'h0);

    assert_pend_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_pending & ~CAP_BITS) == 32'h0);

    assert_addr_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msi_addr[1:0] == 2'b00);

    assert_strobe_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_updated |-> $past(cfg_wr));

endmodule

bind msi_cap_regs msi_cap_regs_chk #(.MMC_LOG2(MMC_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .intx_in(intx_in), .intx_out(intx_out),
    .msi_enable(msi_enable), .msi_mme(msi_mme), .msi_addr(msi_addr),
    .msi_mask(msi_mask), .msi_pending(msi_pending), .cfg_updated(cfg_updated)
);

// File: tb/tb_msi_cap_regs.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected words, a monitor pops them as
// read data returns. dut is 64-bit with masking (cap at 0x50, 8 vectors);
// dut_b is 32-bit without masking (cap at 0x40, 1 vector).
module tb_msi_cap_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_a = 1'b0, wr_b = 1'b0, rd_a = 1'b0, rd_b = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] pset = '0, pclr = '0;
    logic        intx = 1'b0;

    logic [31:0] rdata_a, rdata_b, mask_a, mask_b, pend_a, pend_b;
    logic        rvalid_a, rvalid_b, intxo_a, intxo_b, en_a, en_b, upd_a, upd_b;
    logic [2:0]  mme_a, mme_b;
    logic [63:0] maddr_a, maddr_b;
    logic [15:0] mdata_a, mdata_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          which;
        logic [31:0] exp;
        string       req;
    } rd_item_t;
    rd_item_t sb[$];

    always #2.5 clk = ~clk;

    msi_cap_regs dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr_a), .cfg_rd(rd_a), .cfg_addr(addr),
        .cfg_be(be), .cfg_wdata(wdata), .cfg_rdata(rdata_a), .cfg_rvalid(rvalid_a),
        .pend_set(pset), .pend_clr(pclr), .intx_in(intx), .intx_out(intxo_a),
        .msi_enable(en_a), .msi_mme(mme_a), .msi_addr(maddr_a), .msi_data(mdata_a),
        .msi_mask(mask_a), .msi_pending(pend_a), .cfg_updated(upd_a)
    );

    msi_cap_regs #(
        .ADDR_W(6), .CAP_PTR(8'h40), .NEXT_PTR(8'h00),
        .IS_64(1'b0), .HAS_MASK(1'b0), .MMC_LOG2(0)
    ) dut_b (
        .clk(clk), .rst_n(rst_n), .cfg_wr(wr_b), .cfg_rd(rd_b), .cfg_addr(addr),
        .cfg_be(be), .cfg_wdata(wdata), .cfg_rdata(rdata_b), .cfg_rvalid(rvalid_b),
        .pend_set(32'h0), .pend_clr(32'h0), .intx_in(1'b0), .intx_out(intxo_b),
        .msi_enable(en_b), .msi_mme(mme_b), .msi_addr(maddr_b), .msi_data(mdata_b),
        .msi_mask(mask_b), .msi_pending(pend_b), .cfg_updated(upd_b)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: write one dword to instance a (which=0) or b (which=1)
    task automatic wr(input bit which, input logic [5:0] a, input logic [3:0] e,
                      input logic [31:0] d);
        addr = a; be = e; wdata = d;
        if (which) wr_b = 1'b1; else wr_a = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0; be = '0;
    endtask

    // Driver: issue a read and push the expected word to the scoreboard
    task automatic rd(input bit which, input logic [5:0] a, input logic [31:0] exp,
                      input string req);
        rd_item_t it;
        it.which = which; it.exp = exp; it.req = req;
        sb.push_back(it);
        addr = a;
        if (which) rd_b = 1'b1; else rd_a = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_a = 1'b0; rd_b = 1'b0;
    endtask

    task automatic pulse_pend(input logic [31:0] s, input logic [31:0] c);
        pset = s; pclr = c;
        @(posedge clk);
        @(negedge clk);
        pset = '0; pclr = '0;
    endtask

    // Monitor: compare returned read data against the scoreboard head
    always @(negedge clk) begin
        if (rvalid_a || rvalid_b) begin
            if (sb.size() == 0) begin
                chk("R13 unexpected read data", 64'h1, 64'h0);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                chk(it.req, {32'h0, it.which ? rdata_b : rdata_a}, {32'h0, it.exp});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk("watchdog", 64'h1, 64'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state
        chk("R6 enable", {63'h0, en_a}, 64'h0);
        chk("R6 mme", {61'h0, mme_a}, 64'h0);
        chk("R6 addr", maddr_a, 64'h0);
        chk("R6 mask/pend", {mask_a, pend_a}, 64'h0);
        chk("R12 idle strobe", {63'h0, upd_a}, 64'h0);

        // R1: header layout in both variants
        rd(1'b0, 6'h14, 32'h0186_6005, "R1 hdr 64/mask");
        rd(1'b1, 6'h10, 32'h0000_0005, "R1 hdr 32/nomask");

        // R5: mask limited to 8 capable vectors
        wr(1'b0, 6'h18, 4'hF, 32'hFFFF_FFFF);
        chk("R5 mask out", {32'h0, mask_a}, 64'h0000_00FF);
        rd(1'b0, 6'h18, 32'h0000_00FF, "R5 mask read");

        // R11: pending set limited to capable, then clear bit 0
        pulse_pend(32'hFFFF_FFFF, 32'h0);
        chk("R11 pend set", {32'h0, pend_a}, 64'hFF);
        pulse_pend(32'h0, 32'h1);
        rd(1'b0, 6'h19, 32'h0000_00FE, "R11 pend clr read");

        // R7: count written while disabled is stored raw; R10 no trim
        wr(1'b0, 6'h14, 4'b0100, 32'h0070_0000);
        chk("R7 raw mme", {61'h0, mme_a}, 64'h7);
        chk("R10 no trim while off", {32'h0, pend_a}, 64'hFE);

        // R8: INTx passes while disabled
        intx = 1'b1;
        #1;
        chk("R8 intx pass", {63'h0, intxo_a}, 64'h1);

        // R10/R12: enable with two vectors trims pending above bit 1
        wr(1'b0, 6'h14, 4'b0100, 32'h0011_0000);
        chk("R12 strobe high", {63'h0, upd_a}, 64'h1);
        chk("R10 trimmed", {32'h0, pend_a}, 64'h2);
        chk("R8 intx blocked", {63'h0, intxo_a}, 64'h0);
        chk("R7 mme kept", {61'h0, mme_a}, 64'h1);
        @(negedge clk);
        chk("R12 strobe single", {63'h0, upd_a}, 64'h0);

        // R7: clamp on enabled write
        wr(1'b0, 6'h14, 4'b0100, 32'h0071_0000);
        chk("R7 clamp", {61'h0, mme_a}, 64'h3);

        // R2: only enable and count take writes
        wr(1'b0, 6'h14, 4'hF, 32'hFFFF_FFFF);
        rd(1'b0, 6'h14, 32'h01B7_6005, "R2 hdr after ones");

        // R3: address words
        wr(1'b0, 6'h15, 4'hF, 32'hDEAD_BEEF);
        wr(1'b0, 6'h16, 4'hF, 32'h1234_5678);
        chk("R3 addr", maddr_a, 64'h1234_5678_DEAD_BEEC);
        rd(1'b0, 6'h15, 32'hDEAD_BEEC, "R3 addr lo read");

        // R4: data is 16 bits
        wr(1'b0, 6'h17, 4'hF, 32'hFFFF_A5C3);
        chk("R4 data", {48'h0, mdata_a}, 64'hA5C3);
        rd(1'b0, 6'h17, 32'h0000_A5C3, "R4 data read");

        // R9: writes beyond and before the capability
        wr(1'b0, 6'h1A, 4'hF, 32'hFFFF_FFFF);
        chk("R9 no strobe", {63'h0, upd_a}, 64'h0);
        wr(1'b0, 6'h13, 4'hF, 32'h0000_0000);
        chk("R9 state kept", {mask_a, pend_a}, {32'hFF, 32'h2});
        rd(1'b0, 6'h1A, 32'h0, "R9 outside read");

        // R3/R4/R9 on the 32-bit no-mask variant
        wr(1'b1, 6'h11, 4'hF, 32'h1000_0003);
        chk("R3 32-bit addr", maddr_b, 64'h0000_0000_1000_0000);
        wr(1'b1, 6'h12, 4'b0011, 32'h0000_BEEF);
        chk("R4 32-bit data", {48'h0, mdata_b}, 64'hBEEF);
        wr(1'b1, 6'h12, 4'b1100, 32'hFFFF_0000);
        chk("R9 half-outside no strobe", {63'h0, upd_b}, 64'h0);
        wr(1'b1, 6'h13, 4'hF, 32'hFFFF_FFFF);
        chk("R11 no-mask zero", {mask_b, pend_b}, 64'h0);
        rd(1'b1, 6'h12, 32'h0000_BEEF, "R4 32-bit data read");
        rd(1'b1, 6'h13, 32'h0, "R9 32-bit past end");
        wr(1'b1, 6'h10, 4'b0100, 32'h0021_0000);
        chk("R7 clamp to one vector", {61'h0, mme_b}, 64'h0);

        // R6: reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R6 cleared", {en_a, mme_a, mask_a, pend_a}, 64'h0);
        chk("R6 addr data", maddr_a | {48'h0, mdata_a}, 64'h0);
        rd(1'b0, 6'h14, 32'h0186_6005, "R6 hdr after reset");

        @(negedge clk);
        chk("R13 scoreboard drained", {32'h0, 32'(sb.size())}, 64'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule